// File: doc/BRIEF.md
# Hardware return address stack

This block keeps the return addresses of a processor core. A call or an interrupt pushes the current program counter and a return pops it back. Storage holds 31 words of 21 bits. A 5-bit pointer selects the top entry. Pointer value 0 is an empty position with no storage behind it, and reading it gives zero. The full flag and the underflow flag are sticky. They clear only through a software write or a power-on reset. A warm reset returns the pointer to 0 and leaves both flags as they were.

A byte-wide register port gives software access to the stack. Select 0 is the status byte, which holds both flags and the pointer. Selects 1, 2 and 3 are the upper, high and low bytes of the entry the pointer selects. Through this port software can save and rebuild the stack. One input chooses whether an overflow or an underflow raises a reset request. When it is set, an overflow also stores the incremented address and sends the pointer back to 0.

Top module: `ret_addr_stack`

## Requirements
- R1: A low `por_n` clears the pointer, the full flag, the underflow flag and the reset request. A low `rst_n` clears the pointer and the reset request and leaves both flags unchanged.
- R2: A push at a pointer below 30 adds one to the pointer and stores `push_pc_i` in the entry the new pointer selects. The entry is then visible on `pop_pc_o` and on the top-of-stack bytes.
- R3: While the pointer is above 0, `pop_pc_o` shows the selected entry. A pop decrements the pointer.
- R4: A push at pointer 30 sets the full flag. With `ovf_rst_en_i` low, that push stores the PC in entry 31 and sets the pointer to 31. Later pushes keep the pointer at 31, leave entry 31 unchanged and set the full flag again.
- R5: With `ovf_rst_en_i` high, a push at pointer 30 stores `push_pc_i`+2 in entry 31, with the sum wrapping at 21 bits. It also sets the full flag and sets the pointer to 0. A push at pointer 31 sets the full flag and the pointer to 0 without writing. In both cases `rst_req_o` is high for the single cycle after the edge that took the push.
- R6: At pointer 0, `pop_pc_o` is 0. A pop at pointer 0 sets the underflow flag and leaves the pointer at 0. When `ovf_rst_en_i` is high, it also raises `rst_req_o` for one cycle.
- R7: The full and underflow flags stay set through pushes, pops, top-of-stack writes and `rst_n`. Only a status write or `por_n` clears them.
- R8: Select 0 (`reg_sel_i`=0) reads {bit7 full, bit6 underflow, bit5 0, bits4:0 pointer}. A write at select 0 loads all three fields from the same bit positions.
- R9: Selects 1, 2 and 3 read the top entry's bits 20:16, 15:8 and 7:0. Select 1 reads 0 in bits 7:5. A write at one of these selects replaces that byte of the selected entry. At pointer 0 these selects read 0 and a write to them is ignored.
- R10: Only one operation takes effect in a cycle, in this order: push first, then pop, then a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| rst_n | input | 1 | Warm reset, asynchronous, active low |
| ovf_rst_en_i | input | 1 | Enables the overflow/underflow reset behaviour |
| push_i | input | 1 | Push request (call or interrupt) |
| push_pc_i | input | 21 | PC value to push |
| pop_i | input | 1 | Pop request (return) |
| pop_pc_o | output | 21 | Value delivered to the PC on a pop (top entry, 0 at pointer 0) |
| reg_sel_i | input | 2 | Register select: 0 status, 1 upper, 2 high, 3 low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current select |
| rst_req_o | output | 1 | One-cycle reset request on overflow or underflow |

## Verification
Pushes alone cannot show entry 31 after an overflow reset, because the pointer has already returned to 0 and that entry is out of sight. The bench therefore writes the status byte to put the pointer at 29 and pushes twice. It then writes the pointer to 31 and reads the three top-of-stack bytes to see the stored PC+2. A pushed address of all ones is used so that this sum wraps. Entries are otherwise uninitialised, so the stimulus first fills every entry with pushes. After that, random pointer writes and random pops always read known data, and a behavioural model checks them every cycle.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int AW = 21,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          ovf_rst_en_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_pc_i,
  input  logic          pop_i,
  output logic [AW-1:0] pop_pc_o,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_wr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          rst_req_o
);
  localparam int DEPTH = (1 << PW) - 1;
  localparam logic [PW-1:0] TOP  = PW'(DEPTH);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [AW-1:0] mem [1:DEPTH];
  logic [PW-1:0] ptr, ptr_nx, mem_wa;
  logic          full_q, unf_q, full_nx, unf_nx, req_q, req_nx, mem_we;
  logic [AW-1:0] tos, mem_wd;
  logic [23:0]   tos24, wd24;

  assign tos      = (ptr == '0) ? '0 : mem[ptr];
  assign tos24    = 24'(tos);
  assign pop_pc_o = tos;
  assign rst_req_o = req_q;

  always_comb begin
    case (reg_sel_i)
      2'd0:    reg_rdata_o = {full_q, unf_q, 6'(ptr)};
      2'd1:    reg_rdata_o = tos24[23:16];
      2'd2:    reg_rdata_o = tos24[15:8];
      default: reg_rdata_o = tos24[7:0];
    endcase
  end

  always_comb begin
    ptr_nx  = ptr;
    full_nx = full_q;
    unf_nx  = unf_q;
    req_nx  = 1'b0;
    mem_we  = 1'b0;
    mem_wa  = ptr + PW'(1);
    mem_wd  = push_pc_i;
    wd24    = tos24;
    if (push_i) begin
      if (ptr < LAST) begin
        ptr_nx = ptr + PW'(1);
        mem_we = 1'b1;
      end else begin
        full_nx = 1'b1;
        if (ovf_rst_en_i) begin
          ptr_nx = '0;
          req_nx = 1'b1;
          if (ptr == LAST) begin
            mem_we = 1'b1;
            mem_wd = push_pc_i + AW'(2);
          end
        end else begin
          ptr_nx = TOP;
          mem_we = (ptr == LAST);
        end
      end
    end else if (pop_i) begin
      if (ptr == '0) begin
        unf_nx = 1'b1;
        req_nx = ovf_rst_en_i;
      end else begin
        ptr_nx = ptr - PW'(1);
      end
    end else if (reg_wr_i) begin
      if (reg_sel_i == 2'd0) begin
        full_nx = reg_wdata_i[7];
        unf_nx  = reg_wdata_i[6];
        ptr_nx  = reg_wdata_i[PW-1:0];
      end else if (ptr != '0) begin
        case (reg_sel_i)
          2'd1:    wd24[23:16] = reg_wdata_i;
          2'd2:    wd24[15:8]  = reg_wdata_i;
          default: wd24[7:0]   = reg_wdata_i;
        endcase
        mem_we = 1'b1;
        mem_wa = ptr;
        mem_wd = wd24[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) begin
      ptr   <= '0;
      req_q <= 1'b0;
    end else begin
      ptr   <= ptr_nx;
      req_q <= req_nx;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      full_q <= 1'b0;
      unf_q  <= 1'b0;
    end else if (rst_n) begin
      full_q <= full_nx;
      unf_q  <= unf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we && por_n && rst_n) mem[mem_wa] <= mem_wd;
  end
endmodule

// File: rtl/ret_addr_stack_chk.sv
module ret_addr_stack_chk #(
  parameter int AW = 21,
  parameter int PW = 5
) (
  input logic          clk,
  input logic          por_n,
  input logic          rst_n,
  input logic          ovf_rst_en_i,
  input logic          push_i,
  input logic          pop_i,
  input logic          reg_wr_i,
  input logic [1:0]    reg_sel_i,
  input logic [PW-1:0] ptr,
  input logic          full_q,
  input logic          unf_q,
  input logic [AW-1:0] pop_pc_o,
  input logic          rst_req_o
);
  localparam logic [PW-1:0] TOP  = PW'((1 << PW) - 1);
  localparam logic [PW-1:0] LAST = PW'((1 << PW) - 2);

  logic stat_wr;
  assign stat_wr = reg_wr_i && reg_sel_i == 2'd0 && !push_i && !pop_i;

  assert_push_inc_R2: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    push_i && ptr < LAST |=> ptr == $past(ptr) + PW'(1));
  assert_pop_dec_R3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !push_i && pop_i && ptr != '0 |=> ptr == $past(ptr) - PW'(1));
  assert_hold_top_R4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !ovf_rst_en_i && push_i && ptr == TOP |=> ptr == TOP && full_q);
  assert_ovf_reset_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    ovf_rst_en_i && push_i && ptr == LAST |=> rst_req_o && ptr == '0 && full_q);
  assert_req_cause_R5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rst_req_o |-> $past(ovf_rst_en_i));
  assert_underflow_R6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    !push_i && pop_i && ptr == '0 |=> unf_q && ptr == '0);
  assert_zero_empty_R6: assert property (@(posedge clk) disable iff (!por_n)
    ptr == '0 |-> pop_pc_o == '0);
  assert_full_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    full_q && !stat_wr |=> full_q);
  assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    unf_q && !stat_wr |=> unf_q);
endmodule

bind ret_addr_stack ret_addr_stack_chk #(.AW(AW), .PW(PW)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .ovf_rst_en_i(ovf_rst_en_i),
  .push_i(push_i), .pop_i(pop_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
  .ptr(ptr), .full_q(full_q), .unf_q(unf_q), .pop_pc_o(pop_pc_o),
  .rst_req_o(rst_req_o)
);

// File: tb/ret_addr_stack_test.sv
module ret_addr_stack_test;
  logic        clk = 0;
  logic        por_n = 0, rst_n = 1, ovf = 0;
  logic        push = 0, pop = 0, wr = 0;
  logic [20:0] pc = 0;
  logic [1:0]  sel = 0;
  logic [7:0]  wdata = 0;
  logic [20:0] pop_pc;
  logic [7:0]  rdata;
  logic        req;

  int total = 0, bad = 0;
  string ctx = "R1";
  int m [0:31];
  int mptr = 0;
  bit mfull = 0, munf = 0, mreq = 0;

  always #5 clk = ~clk;

  ret_addr_stack uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ovf_rst_en_i(ovf),
    .push_i(push), .push_pc_i(pc), .pop_i(pop), .pop_pc_o(pop_pc),
    .reg_sel_i(sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .rst_req_o(req)
  );

  function automatic int tos_of();
    return (mptr == 0) ? 0 : m[mptr];
  endfunction

  task automatic model_step();
    int t, nreq;
    nreq = 0;
    if (!por_n) begin
      mptr = 0; mfull = 0; munf = 0; mreq = 0; return;
    end
    if (!rst_n) begin
      mptr = 0; mreq = 0; return;
    end
    if (push) begin
      if (mptr < 30) begin
        mptr++; m[mptr] = int'(pc);
      end else begin
        mfull = 1;
        if (ovf) begin
          if (mptr == 30) m[31] = (int'(pc) + 2) & 'h1FFFFF;
          mptr = 0; nreq = 1;
        end else begin
          if (mptr == 30) m[31] = int'(pc);
          mptr = 31;
        end
      end
    end else if (pop) begin
      if (mptr == 0) begin
        munf = 1; nreq = ovf;
      end else mptr--;
    end else if (wr) begin
      if (sel == 0) begin
        mfull = wdata[7]; munf = wdata[6]; mptr = wdata & 'h1F;
      end else if (mptr != 0) begin
        t = m[mptr];
        case (sel)
          2'd1: t = (t & 'h00FFFF) | ((int'(wdata) & 'h1F) << 16);
          2'd2: t = (t & 'h1F00FF) | (int'(wdata) << 8);
          default: t = (t & 'h1FFF00) | int'(wdata);
        endcase
        m[mptr] = t;
      end
    end
    mreq = nreq[0];
  endtask

  task automatic check(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", ctx, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int erd, t;
    model_step();
    #2;
    t = tos_of();
    case (sel)
      2'd0: erd = (int'(mfull) << 7) | (int'(munf) << 6) | mptr;
      2'd1: erd = (t >> 16) & 'hFF;
      2'd2: erd = (t >> 8) & 'hFF;
      default: erd = t & 'hFF;
    endcase
    check("pop_pc", int'(pop_pc), t);
    check("rdata", int'(rdata), erd);
    check("rst_req", int'(req), int'(mreq));
  end

  task automatic drv(bit ps, int p, bit pp, bit w, int s, int d);
    @(negedge clk);
    push = ps; pc = p[20:0]; pop = pp; wr = w; sel = s[1:0]; wdata = d[7:0];
  endtask

  task automatic idle(int s);
    drv(0, 0, 0, 0, s, 0);
  endtask

  initial begin
    foreach (m[i]) m[i] = 0;
    repeat (3) idle(0);
    @(negedge clk) por_n = 1;
    idle(0);
    ctx = "R2";
    for (int i = 1; i <= 5; i++) drv(1, i * 'h1111 + 'h100, 0, 0, 0, 0);
    ctx = "R9";
    for (int s = 0; s < 4; s++) idle(s);
    ctx = "R3";
    drv(0, 0, 1, 0, 3, 0);
    drv(0, 0, 1, 0, 0, 0);
    ctx = "R4";
    for (int i = 0; i < 40; i++) drv(1, 'h10000 + i * 6, 0, 0, 0, 0);
    idle(0); idle(3);
    ctx = "R6";
    for (int i = 0; i < 33; i++) drv(0, 0, 1, 0, 0, 0);
    idle(0);
    ctx = "R8";
    drv(0, 0, 0, 1, 0, 'h05);
    idle(0);
    ctx = "R9";
    drv(0, 0, 0, 1, 1, 'hFF);
    drv(0, 0, 0, 1, 2, 'hAB);
    drv(0, 0, 0, 1, 3, 'hCD);
    for (int s = 1; s < 4; s++) idle(s);
    drv(0, 0, 0, 1, 0, 'h00);
    drv(0, 0, 0, 1, 3, 'h77);
    idle(3);
    ctx = "R6";
    drv(0, 0, 1, 0, 0, 0);
    ctx = "R7";
    drv(1, 'h1234, 0, 0, 0, 0);
    drv(0, 0, 0, 1, 3, 'h55);
    drv(0, 0, 1, 0, 0, 0);
    idle(0);
    drv(0, 0, 0, 1, 0, 'h03);
    idle(0);
    ctx = "R10";
    drv(1, 'h0F0F0, 1, 1, 0, 'hDF);
    drv(0, 0, 1, 1, 0, 'hDF);
    drv(0, 0, 1, 1, 3, 'h11);
    idle(0);
    ctx = "R1";
    drv(0, 0, 0, 1, 0, 'hC4);
    @(negedge clk) rst_n = 0;
    idle(0);
    @(negedge clk) rst_n = 1;
    idle(0);
    ctx = "R5";
    ovf = 1;
    drv(0, 0, 0, 1, 0, 'h1D);
    drv(1, 'h02468, 0, 0, 0, 0);
    drv(1, 'h1FFFFF, 0, 0, 0, 0);
    idle(0);
    drv(0, 0, 0, 1, 0, 'h1F);
    for (int s = 1; s < 4; s++) idle(s);
    drv(1, 'h00777, 0, 0, 0, 0);
    idle(0);
    ctx = "R6";
    drv(0, 0, 0, 1, 0, 'h00);
    drv(0, 0, 1, 0, 0, 0);
    idle(0);
    ctx = "R1";
    drv(0, 0, 0, 1, 0, 'hC9);
    @(negedge clk) por_n = 0;
    idle(0);
    @(negedge clk) por_n = 1;
    idle(0);
    ctx = "R10";
    for (int i = 0; i < 600; i++) begin
      if (i % 100 == 0) ovf = $urandom_range(0, 1);
      drv($urandom_range(0, 3) == 0, $urandom, $urandom_range(0, 3) == 0,
          $urandom_range(0, 2) == 0, $urandom_range(0, 3), $urandom);
    end
    idle(0); idle(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule